// File: doc/BRIEF.md
# A1/A2 Word-Boundary Framer

The framer takes the deserialized receive stream as unaligned 16-bit words. Each word is one slice of the serial line, with the earliest bit in bit 15. It looks for the SONET/SDH framing run made of two A1 bytes followed by two A2 bytes, at any of the 16 possible bit offsets. When it finds the run, it fixes the word boundary so that the first A2 byte opens an output word, and every later output word follows on from there.

Acquisition does not run continuously. A rising edge on the out-of-frame input starts a search, and the frame-enable input must be high when that edge is sampled. Once the run is found, the framer pulses `frame_o` for one cycle, raises `lock_o` and holds the chosen offset. It ignores any further framing patterns until the next out-of-frame edge. While frame-enable is low, the framer ignores out-of-frame edges, drops any search in progress and keeps both the offset and the lock flag as they are.

Top module: `a1a2_framer`

## Requirements
- R1: The framing run is the 32-bit value 0xF6F62828 (A1 = 0xF6 twice, then A2 = 0x28 twice), taken from the stream with `data_i[15]` as the earliest bit of each word. It is recognised at any bit offset. If more than one offset matches in the same cycle, the earliest-arriving position wins.
- R2: After a detection, `data_o` carries 16 consecutive stream bits each cycle. In the pulse cycle, `data_o` is 0x2828, so the first A2 byte sits in bits [15:8]. Each later cycle holds the next 16 stream bits.
- R3: `frame_o` is high for exactly one cycle per acquisition. If the run's first bit lies in the `data_i` word sampled at clock edge n, the pulse is seen after edge n+3, in the same cycle as the first aligned word.
- R4: A rising edge of `oof_i` sampled while `frm_en_i` is high starts a search and clears `lock_o` from the next cycle until a detection.
- R5: `lock_o` rises in the same cycle as `frame_o`. It never rises without a frame pulse.
- R6: Once locked, the framer raises no frame pulse for later framing runs at other offsets and keeps the data alignment, for as long as `oof_i` has no new rising edge.
- R7: While `frm_en_i` is low, `oof_i` edges have no effect, no frame pulse occurs, and `lock_o` and the alignment stay unchanged.
- R8: While `rst_ni` is low, `data_o`, `frame_o` and `lock_o` are zero and the offset is cleared.
- R9: A new `oof_i` rising edge with `frm_en_i` high, after a lock, re-acquires on the next framing run and moves the alignment to that run's offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 16 | Unaligned received word, bit 15 earliest |
| frm_en_i | input | 1 | Frame-search enable |
| oof_i | input | 1 | Out-of-frame indication; rising edge starts a search |
| data_o | output | 16 | Word-aligned data |
| frame_o | output | 1 | One-cycle pulse on the first aligned word after detection |
| lock_o | output | 1 | Alignment held from a completed search |

## Verification
The hardest case to reach from the ports is a locked framer meeting a second framing run at a different offset. It must keep the old boundary (R6), keep it with enable low (R7), or move to the new one (R9), depending on how enable and out-of-frame were driven just before. Each run builds one bit stream that holds two framing runs, 21 words apart, with their offsets swept together over all 16 values. Each run applies one of the three control patterns between the two runs. Every output word after the first lock is checked against the stream bits that the expected boundary selects.

// File: rtl/a1a2_framer_pkg.sv
package a1a2_framer_pkg;
  localparam int unsigned WORD_DEF = 16;
  localparam logic [7:0]  A1_DEF   = 8'hF6;
  localparam logic [7:0]  A2_DEF   = 8'h28;
endpackage

// File: rtl/framer_rise.sv
module framer_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/framer_window.sv
module framer_window #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 3,
  localparam int unsigned WIN_W = WORD_W * DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  output logic [WIN_W-1:0]  win_o
);
  logic [WORD_W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= data_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end

  // oldest word in the top bits
  for (genvar g = 0; g < DEPTH; g++) begin : g_win
    assign win_o[g*WORD_W +: WORD_W] = stage_q[g];
  end
endmodule

// File: rtl/framer_search.sv
module framer_search #(
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W/2-1:0] A1 = 8'hF6,
  parameter logic [WORD_W/2-1:0] A2 = 8'h28,
  localparam int unsigned PAT_W = 2 * WORD_W,
  localparam int unsigned WIN_W = 3 * WORD_W,
  localparam int unsigned OFF_W = $clog2(WORD_W)
) (
  input  logic [WIN_W-1:0] win_i,
  output logic             hit_o,
  output logic [OFF_W-1:0] pos_o
);
  localparam logic [PAT_W-1:0] PAT = {A1, A1, A2, A2};

  logic [WORD_W-1:0] match;
  for (genvar p = 0; p < WORD_W; p++) begin : g_cmp
    assign match[p] = (win_i[WIN_W-1-p -: PAT_W] == PAT);
  end

  // lowest offset = earliest arriving
  always_comb begin
    pos_o = '0;
    for (int p = WORD_W - 1; p >= 0; p--)
      if (match[p]) pos_o = OFF_W'(p);
  end
  assign hit_o = |match;
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned OFF_W = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             oof_rise_i,
  input  logic             hit_i,
  input  logic [OFF_W-1:0] pos_i,
  output logic [OFF_W-1:0] sel_o,
  output logic             frame_o,
  output logic             lock_o
);
  logic             hunt_q;
  logic [OFF_W-1:0] off_q;
  logic             take;

  assign take  = en_i & ~oof_rise_i & hunt_q & hit_i;
  assign sel_o = take ? pos_i : off_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hunt_q  <= 1'b0;
      off_q   <= '0;
      frame_o <= 1'b0;
      lock_o  <= 1'b0;
    end else begin
      frame_o <= 1'b0;
      if (!en_i) begin
        hunt_q <= 1'b0;          // abandon, keep alignment
      end else if (oof_rise_i) begin
        hunt_q <= 1'b1;
        lock_o <= 1'b0;
      end else if (take) begin
        hunt_q  <= 1'b0;
        off_q   <= pos_i;
        lock_o  <= 1'b1;
        frame_o <= 1'b1;
      end
    end
endmodule

// File: rtl/a1a2_framer.sv
module a1a2_framer
  import a1a2_framer_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_DEF,
  parameter logic [WORD_W/2-1:0] A1 = A1_DEF,
  parameter logic [WORD_W/2-1:0] A2 = A2_DEF,
  localparam int unsigned PAT_W = 2 * WORD_W,
  localparam int unsigned WIN_W = 3 * WORD_W,
  localparam int unsigned OFF_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              frm_en_i,
  input  logic              oof_i,
  output logic [WORD_W-1:0] data_o,
  output logic              frame_o,
  output logic              lock_o
);
  logic [WIN_W-1:0] win;
  logic             oof_rise;
  logic             hit;
  logic [OFF_W-1:0] pos;
  logic [OFF_W-1:0] sel;

  framer_rise u_rise (
    .clk_i (clk_i), .rst_ni (rst_ni), .sig_i (oof_i), .rise_o (oof_rise)
  );

  framer_window #(.WORD_W(WORD_W), .DEPTH(3)) u_win (
    .clk_i (clk_i), .rst_ni (rst_ni), .data_i (data_i), .win_o (win)
  );

  framer_search #(.WORD_W(WORD_W), .A1(A1), .A2(A2)) u_search (
    .win_i (win), .hit_o (hit), .pos_o (pos)
  );

  framer_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (frm_en_i),
    .oof_rise_i (oof_rise),
    .hit_i      (hit),
    .pos_i      (pos),
    .sel_o      (sel),
    .frame_o    (frame_o),
    .lock_o     (lock_o)
  );

  // first A2 byte lands in the upper half of the word
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) data_o <= '0;
    else         data_o <= win[PAT_W-1-sel -: WORD_W];
endmodule

// File: rtl/a1a2_framer_chk.sv
module a1a2_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic frm_en_i,
  input logic oof_i,
  input logic frame_o,
  input logic lock_o
);
  // R3
  frame_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  // R5
  frame_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> lock_o);

  // R5
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> frame_o);

  // R4
  search_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_en_i && $rose(oof_i)) |=> !lock_o);

  // R7
  dis_no_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_en_i |=> !frame_o);

  // R7
  dis_lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_en_i |=> $stable(lock_o));
endmodule

bind a1a2_framer a1a2_framer_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .frm_en_i (frm_en_i),
  .oof_i    (oof_i),
  .frame_o  (frame_o),
  .lock_o   (lock_o)
);

// File: tb/a1a2_framer_tb_top.sv
`timescale 1ns/1ps
module a1a2_framer_tb_top;
  localparam int unsigned NW  = 48;
  localparam int unsigned NB  = NW * 16;
  localparam logic [31:0] PAT = 32'hF6F62828;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic        frm_en_i = 1'b1;
  logic        oof_i = 1'b0;
  logic [15:0] data_o;
  logic        frame_o;
  logic        lock_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic stream [NB];

  always #2 clk_i = ~clk_i;

  a1a2_framer dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .data_i (data_i),
    .frm_en_i (frm_en_i), .oof_i (oof_i),
    .data_o (data_o), .frame_o (frame_o), .lock_o (lock_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] bits_at(int pos);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) w[15-i] = stream[pos+i];
    return w;
  endfunction

  // mode 0: re-search (R9), 1: enable low (R7), 2: no new edge (R6)
  task automatic run(int k1, int k2, int mode);
    int p1, p2, e1, e2, a1, a2;
    logic [15:0] fw;
    p1 = 64 + k1;  p2 = 400 + k2;
    e1 = p1 / 16 + 3;  e2 = p2 / 16 + 3;
    a1 = p1 + 16;  a2 = p2 + 16;
    for (int w = 0; w < NW; w++) begin
      fw = 16'h3C00 | 16'(w & 31);
      for (int i = 0; i < 16; i++) stream[w*16+i] = fw[15-i];
    end
    for (int i = 0; i < 32; i++) begin
      stream[p1+i] = PAT[31-i];
      stream[p2+i] = PAT[31-i];
    end
    for (int e = 0; e < NW; e++) begin
      data_i = bits_at(e * 16);
      frm_en_i = !(mode == 1 && e >= 18 && e < 44);
      oof_i = (e < 16) || (mode != 2 && e >= 18 && e < 40);
      @(posedge clk_i);
      @(negedge clk_i);
      // R3 R1: frame pulse position
      chk("R3", {15'd0, frame_o},
          {15'd0, (e == e1) || (mode == 0 && e == e2)});
      if (e >= 1 && e < e1) chk("R4", {15'd0, lock_o}, 16'd0);
      else if (e >= e1 && e < 18) chk("R5", {15'd0, lock_o}, 16'd1);
      else if (e >= 19 && e < e2)
        chk(mode == 0 ? "R9" : (mode == 1 ? "R7" : "R6"),
            {15'd0, lock_o}, {15'd0, mode != 0});
      else if (e >= e2) chk("R5", {15'd0, lock_o}, 16'd1);
      if (e == e1) chk("R1", data_o, 16'h2828);
      if (e >= e1 && e < 46) begin
        if (mode == 0 && e >= e2) chk("R9", data_o, bits_at(a2 + 16 * (e - e2)));
        else if (e < 18) chk("R2", data_o, bits_at(a1 + 16 * (e - e1)));
        else chk(mode == 1 ? "R7" : (mode == 2 ? "R6" : "R2"),
                 data_o, bits_at(a1 + 16 * (e - e1)));
      end
    end
  endtask

  initial begin
    #1;
    chk("R8", data_o, 16'h0000);
    chk("R8", {14'd0, frame_o, lock_o}, 16'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < 16; k++) run(k, (k + 5) % 16, k % 3);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R8", data_o, 16'h0000);
    chk("R8", {14'd0, frame_o, lock_o}, 16'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule